// File: doc/BRIEF.md
# Pipelined Virtual Logic Array

This block is a small programmable logic fabric built from ordinary registers and multiplexers. Eighty 1-bit logic cells sit in ten rows and eight stages. Each cell picks two operands from the stage before it and applies one of eight Boolean operations. Cell outputs are registered at the end of every stage, so the array accepts a new 6-bit input vector on every clock. It returns a 6-bit result a fixed eight clocks later. Cells are numbered stage-major: cell number = stage × 10 + row.

The whole behaviour of the array comes from a register-held configuration image. A search engine on the same die can rewrite this image in eight consecutive clock cycles through a simple column-wide write port. One beat carries the settings of every cell of one stage. The stage pointer advances by itself, and a one-cycle done pulse marks the end of a complete image. The data path is a streaming pipe with a valid flag on each side and no ready signal. It never stalls: the upstream may present one vector per clock, and the downstream must take each result in the cycle it is flagged. The configuration is expected to stay untouched while vectors are in flight.

Top module: `vrc_array`

## Requirements
- R1: While reset is held and right after it, out_valid, out_data and cfg_done are 0. Every configuration bit is cleared, so the array computes AND with both operands at select 0. Each output then equals in_data[0].
- R2: Each clock with cfg_valid high writes cfg_col into one stage, in stage order 0,1,…,7. After stage 7 the next beat goes to stage 0 again. Idle cycles between beats neither advance nor disturb the pointer.
- R3: cfg_done is high for exactly one clock, the one after the beat that wrote stage 7, and is low at every other time.
- R4: Within cfg_col, the cell of row r uses bits [11r+10:11r]. Inside that field, bits [3:0] select operand A, bits [7:4] select operand B, and bits [10:8] select the operation.
- R5: Operation codes: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR, 6 NOT A, 7 A unchanged.
- R6: A stage-0 cell takes operand in_data[s mod 6], where s is its 4-bit select value. A cell in stage k>0 takes the registered output of row (s mod 10) in stage k−1.
- R7: out_data[j] is the registered output of row 2+j in stage 7, which is cell 72+j.
- R8: A vector accepted with in_valid high shows up on out_data eight clocks later, with out_valid high in that cycle. out_valid repeats the in_valid pattern delayed by exactly eight clocks. Back-to-back vectors are accepted on every clock.
- R9: A second full load replaces the earlier configuration. Vectors applied after it follow only the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Configuration beat strobe |
| cfg_col | input | 110 | Settings of the ten cells of one stage |
| cfg_done | output | 1 | One-clock pulse after the last stage of an image is written |
| in_valid | input | 1 | Input vector valid |
| in_data | input | 6 | Input vector |
| out_valid | output | 1 | Result valid |
| out_data | output | 6 | Result vector, from cells 72 to 77 |

## Verification
The array is driven with all 64 input vectors under several images. The cleared reset image shows whether the output follows in_data[0]. A routing image that passes row r straight through every stage reveals the row-to-output mapping, the first-stage wrap and any stage slip. Two operation-sweep images place every operation code on some output, so each code is told apart by its truth table. A select-wrap image and a pseudo-random image, both using out-of-range selects, separate the modulo-6 and modulo-10 operand choice from a plain truncation. Images are loaded with and without idle gaps, and vectors are streamed both back to back and with holes, which exposes pointer drift, a misplaced done pulse and any valid-delay error.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int SEL_W    = 4;
  localparam int FN_W     = 3;
  localparam int PE_CFG_W = 2 * SEL_W + FN_W;

  typedef enum logic [FN_W-1:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_XOR  = 3'd2,
    FN_NAND = 3'd3,
    FN_NOR  = 3'd4,
    FN_XNOR = 3'd5,
    FN_NOTA = 3'd6,
    FN_PASS = 3'd7
  } pe_fn_e;

  typedef struct packed {
    logic [FN_W-1:0]  fn;
    logic [SEL_W-1:0] sel_b;
    logic [SEL_W-1:0] sel_a;
  } pe_cfg_t;

  function automatic logic pe_apply(pe_fn_e f, logic a, logic b);
    case (f)
      FN_AND:  pe_apply = a & b;
      FN_OR:   pe_apply = a | b;
      FN_XOR:  pe_apply = a ^ b;
      FN_NAND: pe_apply = ~(a & b);
      FN_NOR:  pe_apply = ~(a | b);
      FN_XNOR: pe_apply = ~(a ^ b);
      FN_NOTA: pe_apply = ~a;
      default: pe_apply = a;
    endcase
  endfunction
endpackage

// File: rtl/vrc_pe.sv
module vrc_pe
  import vrc_pkg::*;
#(
  parameter int N_SRC = 10
) (
  input  logic [N_SRC-1:0]    src,
  input  logic [PE_CFG_W-1:0] cfg,
  output logic                y
);
  localparam int PAD_W = 2 ** SEL_W;
  localparam logic [SEL_W-1:0] NSRC = SEL_W'(N_SRC);

  pe_cfg_t          c;
  logic [PAD_W-1:0] src_pad;
  logic [SEL_W-1:0] idx_a, idx_b;

  assign c       = pe_cfg_t'(cfg);
  assign src_pad = PAD_W'(src);
  assign idx_a   = c.sel_a % NSRC;
  assign idx_b   = c.sel_b % NSRC;

  always_comb begin
    y = pe_apply(pe_fn_e'(c.fn), src_pad[idx_a], src_pad[idx_b]);
  end
endmodule

// File: rtl/vrc_stage.sv
module vrc_stage
  import vrc_pkg::*;
#(
  parameter int ROWS  = 10,
  parameter int N_SRC = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         src,
  input  logic [ROWS*PE_CFG_W-1:0] cfg,
  output logic [ROWS-1:0]          q
);
  logic [ROWS-1:0] y;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    vrc_pe #(.N_SRC(N_SRC)) u_pe (
      .src (src),
      .cfg (cfg[r*PE_CFG_W +: PE_CFG_W]),
      .y   (y[r])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= y;
  end
endmodule

// File: rtl/vrc_cfg_mem.sv
module vrc_cfg_mem #(
  parameter int COLS  = 8,
  parameter int COL_W = 110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [COL_W-1:0]      wr_col,
  output logic [COLS*COL_W-1:0] image,
  output logic                  done
);
  localparam int PTR_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(COLS - 1);

  logic [COL_W-1:0] mem [COLS];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      done <= 1'b0;
    end else begin
      done <= wr_valid && (ptr == LAST);
      if (wr_valid) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[c] <= '0;
      else if (wr_valid && ptr == PTR_W'(c))       mem[c] <= wr_col;
    end
    assign image[c*COL_W +: COL_W] = mem[c];
  end
endmodule

// File: rtl/vrc_array.sv
module vrc_array
  import vrc_pkg::*;
#(
  parameter int ROWS     = 10,
  parameter int COLS     = 8,
  parameter int N_IN     = 6,
  parameter int N_OUT    = 6,
  parameter int OUT_ROW0 = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_valid,
  input  logic [ROWS*PE_CFG_W-1:0] cfg_col,
  output logic                     cfg_done,
  input  logic                     in_valid,
  input  logic [N_IN-1:0]          in_data,
  output logic                     out_valid,
  output logic [N_OUT-1:0]         out_data
);
  localparam int COL_W = ROWS * PE_CFG_W;

  logic [COLS*COL_W-1:0] image;
  logic [ROWS-1:0]       stage_q [COLS];
  logic [COLS-1:0]       vld_sr;

  vrc_cfg_mem #(.COLS(COLS), .COL_W(COL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (cfg_valid),
    .wr_col   (cfg_col),
    .image    (image),
    .done     (cfg_done)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_stage
    if (c == 0) begin : g_first
      vrc_stage #(.ROWS(ROWS), .N_SRC(N_IN)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (in_data),
        .cfg   (image[c*COL_W +: COL_W]),
        .q     (stage_q[c])
      );
    end else begin : g_next
      vrc_stage #(.ROWS(ROWS), .N_SRC(ROWS)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (stage_q[c-1]),
        .cfg   (image[c*COL_W +: COL_W]),
        .q     (stage_q[c])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_sr <= '0;
    else        vld_sr <= COLS'({vld_sr, in_valid});
  end

  assign out_valid = vld_sr[COLS-1];
  assign out_data  = stage_q[COLS-1][OUT_ROW0 +: N_OUT];
endmodule

// File: rtl/vrc_array_chk.sv
module vrc_array_chk #(
  parameter int COLS  = 8,
  parameter int N_OUT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_done,
  input logic             in_valid,
  input logic             out_valid,
  input logic [N_OUT-1:0] out_data
);
  localparam int CW = $clog2(COLS + 1);

  logic [COLS-1:0] vin_hist;
  logic [CW-1:0]   beats;
  logic            last_beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vin_hist    <= '0;
      beats       <= '0;
      last_beat_q <= 1'b0;
    end else begin
      vin_hist    <= COLS'({vin_hist, in_valid});
      last_beat_q <= cfg_valid && (beats == CW'(COLS - 1));
      if (cfg_valid) beats <= (beats == CW'(COLS - 1)) ? '0 : beats + 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !cfg_done));

  // R3
  done_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done == last_beat_q);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !cfg_done);

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vin_hist[COLS-1]);

  // R7
  data_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data));
endmodule

bind vrc_array vrc_array_chk #(.COLS(COLS), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_done  (cfg_done),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_vrc_array.sv
`timescale 1ns/1ps
module sim_vrc_array;
  localparam int ROWS = 10, COLS = 8, NIN = 6, NOUT = 6, CW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [ROWS*CW-1:0] cfg_col = '0;
  logic cfg_done;
  logic in_valid = 1'b0;
  logic [NIN-1:0] in_data = '0;
  logic out_valid;
  logic [NOUT-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [CW-1:0] bcfg [COLS][ROWS];

  always #10 clk = ~clk;

  vrc_array u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_col(cfg_col),
    .cfg_done(cfg_done), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R5 operation codes
  function automatic logic op(logic [2:0] f, logic a, logic b);
    case (f)
      3'd0: return a & b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return !(a & b);
      3'd4: return !(a | b);
      3'd5: return !(a ^ b);
      3'd6: return !a;
      default: return a;
    endcase
  endfunction

  // R4 field layout, R6 operand wrap, R7 output rows
  function automatic logic [NOUT-1:0] model(logic [NIN-1:0] x);
    logic [ROWS-1:0] prev, cur;
    prev = '0;
    cur  = '0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        int n, ia, ib;
        logic a, b;
        n  = (c == 0) ? NIN : ROWS;
        ia = int'(bcfg[c][r][3:0]) % n;
        ib = int'(bcfg[c][r][7:4]) % n;
        a  = (c == 0) ? x[ia] : prev[ia];
        b  = (c == 0) ? x[ib] : prev[ib];
        cur[r] = op(bcfg[c][r][10:8], a, b);
      end
      prev = cur;
    end
    return cur[2 +: NOUT];
  endfunction

  function automatic logic [CW-1:0] pe(int fn, int a, int b);
    return {3'(fn), 4'(b), 4'(a)};
  endfunction

  task automatic cfg_zero();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) bcfg[c][r] = '0;
  endtask

  task automatic cfg_route();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) bcfg[c][r] = pe(7, r, 0);
  endtask

  task automatic cfg_sweep(input int s);
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        bcfg[c][r] = (c == 0) ? pe((r + s) % 8, 0, 1) : pe(7, r, 0);
  endtask

  task automatic cfg_wrap();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        bcfg[c][r] = pe((r + c) % 6, 15 - (r % 6), 10 + (r % 6));
  endtask

  task automatic cfg_lfsr();
    logic [15:0] s;
    s = 16'hACE1;
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) begin
        s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        bcfg[c][r] = s[10:0];
      end
  endtask

  // R2, R3: load an image, optionally with idle gaps between beats
  task automatic load(input bit gaps, input string tag);
    for (int c = 0; c < COLS; c++) begin
      if (gaps && (c % 3 == 1)) begin
        @(negedge clk);
        cfg_valid = 1'b0;
        @(negedge clk);
        chk(cfg_done == 1'b0, {"R3 idle gap ", tag}, cfg_done, 0);
      end
      @(negedge clk);
      chk(cfg_done == 1'b0, {"R3 no early done ", tag}, cfg_done, 0);
      cfg_valid = 1'b1;
      for (int r = 0; r < ROWS; r++) cfg_col[r*CW +: CW] = bcfg[c][r];
    end
    @(negedge clk);
    chk(cfg_done == 1'b1, {"R3 done after last beat ", tag}, cfg_done, 1);
    cfg_valid = 1'b0;
    cfg_col = '0;
    @(negedge clk);
    chk(cfg_done == 1'b0, {"R3 done one clock ", tag}, cfg_done, 0);
  endtask

  // R8: stream 64 vectors, mode 1 leaves holes in in_valid
  task automatic stream(input int mode, input string tag);
    logic [NIN-1:0] hd [64];
    bit hv [64];
    for (int n = 0; n < 64 + COLS; n++) begin
      @(negedge clk);
      if (n >= COLS) begin
        int i;
        i = n - COLS;
        chk(out_valid == hv[i], {"R8 valid delay ", tag}, out_valid, hv[i]);
        if (hv[i])
          chk(out_data == model(hd[i]), {"R6 R7 data ", tag}, out_data, model(hd[i]));
      end else begin
        chk(out_valid == 1'b0, {"R8 no early valid ", tag}, out_valid, 0);
      end
      if (n < 64) begin
        hd[n] = NIN'((n * 37 + 5) & 63);
        hv[n] = (mode == 0) ? 1'b1 : (n % 3 != 0);
        in_valid = hv[n];
        in_data  = hd[n];
      end else begin
        in_valid = 1'b0;
        in_data  = '0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(out_data == '0, "R1 reset out_data", out_data, 0);
    chk(cfg_done == 1'b0, "R1 reset cfg_done", cfg_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R1: cleared image gives in_data[0] on every output
  task automatic t_cleared();
    cfg_zero();
    stream(0, "R1 cleared image");
  endtask

  initial begin
    t_reset();
    t_cleared();
    cfg_route();    load(1'b0, "route");   stream(0, "R6 route");
    cfg_sweep(0);   load(1'b1, "sweep0");  stream(0, "R5 sweep0");
    cfg_sweep(6);   load(1'b0, "sweep6");  stream(0, "R5 R9 sweep6");
    cfg_wrap();     load(1'b1, "wrap");    stream(1, "R6 wrap");
    cfg_lfsr();     load(1'b0, "lfsr");    stream(0, "R9 lfsr");
    stream(1, "R8 holes");
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule